// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the operating mode of a small processor core and decides the next mode. A change starts when the core reports that it has executed its sleep instruction, or when a wake-up event arrives. The modes are:

- two active modes on the main clock: high-speed and medium-speed;
- three wait modes: sleep, software standby and watch;
- subactive, which runs from the subclock;
- subsleep, its matching wait mode.

A six-bit configuration register steers each sleep instruction. It can send the core into one of the wait modes, or straight into the other active clock domain. From the mode register the block drives the clock enables for the main clock, the subclock and the CPU clock.

Some requests are not allowed. The block refuses these: entering watch or subactive from medium-speed mode, and entering a mode that needs the subclock while the subclock is turned off. On a refused request the mode does not change and a sticky error flag is raised. A build-time parameter removes subclock support. In that build the subclock-related configuration bits read as zero and cannot be written.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is high-speed (code 0), the configuration register reads 0, `req_err` is 0, and all three clock enables are 1.
- R2: The configuration register is written when `cfg_we` is high, and reads back on `cfg_rdata` one cycle later. Its fields are: bit0 direct-transfer, bit1 low-speed, bit2 standby-select, bit3 watch-select, bit4 subclock-off, bit5 medium-select.
- R3: The mode codes are 0 high-speed, 1 medium-speed, 2 sleep, 3 software standby, 4 watch, 5 subactive and 6 subsleep. In an active main-clock mode, a cycle without a sleep request moves the mode to medium-speed if medium-select is 1, and to high-speed otherwise.
- R4: A sleep request in high- or medium-speed mode selects its target by priority: watch-select gives watch; otherwise standby-select gives standby; otherwise direct-transfer and low-speed both set give subactive; otherwise the target is sleep. The new mode is visible the cycle after the request.
- R5: A sleep request in subactive mode targets watch if watch-select is 1. Otherwise it targets high-speed if direct-transfer is 1 and low-speed is 0. In all other cases it targets subsleep.
- R6: A watch or subactive target is refused in these cases: the request comes from medium-speed mode, subclock-off is 1, or subclock support is absent. A refused request leaves the mode unchanged and sets `req_err`, which then stays at 1 until reset.
- R7: A wake event in sleep or software standby returns the mode to the active mode (high- or medium-speed) that was current when the wait mode was entered.
- R8: A wake event in watch mode goes to subactive if low-speed is 1, and to high-speed if it is 0. A wake event in subsleep goes to subactive.
- R9: A sleep request in any wait mode has no effect, and a wake event in any active mode has no effect.
- R10: The enables depend on the mode as follows:
  - `cpu_clk_en` is 1 only in high-speed, medium-speed and subactive.
  - `main_clk_en` is 0 in standby, watch, subactive and subsleep.
  - `sub_clk_en` is 1 when subclock-off is 0, and also in watch, subactive and subsleep.
- R11: With `HAS_SUB` = 0, bits 0, 1 and 4 always read 0 and writes to them are dropped, and `sub_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | One-cycle pulse: the sleep instruction was executed |
| wake | input | 1 | Wake-up or interrupt event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_rdata | output | 6 | Configuration read data |
| mode | output | 3 | Current mode code |
| main_clk_en | output | 1 | Main clock enable |
| sub_clk_en | output | 1 | Subclock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| req_err | output | 1 | Sticky flag for a refused request |

## Verification
The assertions check the following on every cycle:

- the error flag stays set once raised;
- wait modes hold still when no wake event arrives;
- subsleep always wakes into subactive;
- a refused entry from medium-speed mode keeps the mode;
- the standby-select priority holds;
- the CPU clock and main clock are gated in the modes where they must be.

The choice of mode that a wake event returns to, the full target priority over every configuration, and the masking of the subclock bits show only in the bench's scenarios. The bench sweeps all 64 configuration values from an active start and from a subactive start, with and without subclock support.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;
  localparam int CFG_W  = 6;

  typedef enum logic [MODE_W-1:0] {
    M_HIGH   = 3'd0,
    M_MED    = 3'd1,
    M_SLEEP  = 3'd2,
    M_SSTBY  = 3'd3,
    M_WATCH  = 3'd4,
    M_SUBACT = 3'd5,
    M_SUBSLP = 3'd6
  } mode_e;

  typedef struct packed {
    logic med_sel;
    logic sub_off;
    logic watch_sel;
    logic stby_sel;
    logic low_spd;
    logic direct;
  } cfg_t;
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
#(
  parameter bit HAS_SUB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg,
  output logic [CFG_W-1:0] rdata
);
  localparam logic [CFG_W-1:0] WMASK = HAS_SUB ? 6'b111111 : 6'b101100;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg   = cfg_t'(cfg_q);
  assign rdata = cfg_q;
endmodule

// File: rtl/lpm_next.sv
module lpm_next
  import lpm_pkg::*;
#(
  parameter bit HAS_SUB = 1'b1
) (
  input  mode_e cur,
  input  mode_e ret,
  input  cfg_t  cfg,
  input  logic  sleep_req,
  input  logic  wake,
  output mode_e nxt,
  output logic  ret_ld,
  output logic  illegal
);
  mode_e tgt;
  logic  sub_ok;

  always_comb begin
    nxt     = cur;
    ret_ld  = 1'b0;
    illegal = 1'b0;
    tgt     = M_SLEEP;
    sub_ok  = HAS_SUB && !cfg.sub_off;
    case (cur)
      M_HIGH, M_MED: begin
        if (sleep_req) begin
          if (cfg.watch_sel)                    tgt = M_WATCH;
          else if (cfg.stby_sel)                tgt = M_SSTBY;
          else if (cfg.direct && cfg.low_spd)   tgt = M_SUBACT;
          else                                  tgt = M_SLEEP;
          if ((tgt == M_WATCH || tgt == M_SUBACT) && (cur == M_MED || !sub_ok)) begin
            illegal = 1'b1;
          end else begin
            nxt    = tgt;
            ret_ld = (tgt == M_SLEEP) || (tgt == M_SSTBY);
          end
        end else begin
          nxt = cfg.med_sel ? M_MED : M_HIGH;
        end
      end
      M_SUBACT: begin
        if (sleep_req) begin
          if (cfg.watch_sel)                    tgt = M_WATCH;
          else if (cfg.direct && !cfg.low_spd)  tgt = M_HIGH;
          else                                  tgt = M_SUBSLP;
          if (tgt == M_WATCH && !sub_ok) illegal = 1'b1;
          else                           nxt = tgt;
        end
      end
      M_SLEEP, M_SSTBY: if (wake) nxt = ret;
      M_WATCH:          if (wake) nxt = cfg.low_spd ? M_SUBACT : M_HIGH;
      M_SUBSLP:         if (wake) nxt = M_SUBACT;
      default:          nxt = M_HIGH;
    endcase
  end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
#(
  parameter bit HAS_SUB = 1'b1
) (
  input  mode_e mode,
  input  logic  sub_off,
  output logic  main_en,
  output logic  sub_en,
  output logic  cpu_en
);
  logic on_sub;

  always_comb begin
    on_sub  = (mode == M_WATCH) || (mode == M_SUBACT) || (mode == M_SUBSLP);
    main_en = !(on_sub || mode == M_SSTBY);
    cpu_en  = (mode == M_HIGH) || (mode == M_MED) || (mode == M_SUBACT);
    sub_en  = HAS_SUB && (!sub_off || on_sub);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter bit HAS_SUB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [MODE_W-1:0] mode,
  output logic              main_clk_en,
  output logic              sub_clk_en,
  output logic              cpu_clk_en,
  output logic              req_err
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  cfg_t       cfg;
  mode_e      mode_q;
  mode_e      ret_q;
  mode_e      mode_d;
  logic       mode_ld;
  logic       ret_ld;
  logic       illegal;
  logic       err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  lpm_cfg_reg #(.HAS_SUB(HAS_SUB)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  lpm_next #(.HAS_SUB(HAS_SUB)) u_next (
    .cur(mode_q), .ret(ret_q), .cfg(cfg), .sleep_req(sleep_req), .wake(wake),
    .nxt(mode_d), .ret_ld(ret_ld), .illegal(illegal)
  );

  assign mode_ld = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= M_HIGH;
    end else if (mode_ld) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ret_q <= M_HIGH;
    end else if (ret_ld) begin
      ret_q <= mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_q <= 1'b0;
    end else if (illegal) begin
      err_q <= 1'b1;
    end
  end

  lpm_clk_gate #(.HAS_SUB(HAS_SUB)) u_gate (
    .mode(mode_q), .sub_off(cfg.sub_off),
    .main_en(main_clk_en), .sub_en(sub_clk_en), .cpu_en(cpu_clk_en)
  );

  assign mode    = mode_q;
  assign req_err = err_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       wake,
  input logic [5:0] cfg_rdata,
  input logic [2:0] mode,
  input logic       main_clk_en,
  input logic       cpu_clk_en,
  input logic       req_err
);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);

  // R6
  med_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && mode == 3'd1 && cfg_rdata[3]) |=> (mode == 3'd1 && req_err));

  // R4
  stby_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && (mode == 3'd0 || mode == 3'd1) && !cfg_rdata[3] && cfg_rdata[2])
    |=> (mode == 3'd3));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3 || mode == 3'd4 || mode == 3'd6) && !wake)
    |=> $stable(mode));

  // R8
  subslp_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && mode == 3'd6) |=> (mode == 3'd5));

  // R10
  cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 || mode == 3'd3 || mode == 3'd4 || mode == 3'd6) |-> !cpu_clk_en);

  // R10
  main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 || mode == 3'd3) |-> !main_clk_en);

  // R3
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sleep_req(sleep_req), .wake(wake),
  .cfg_rdata(cfg_rdata), .mode(mode), .main_clk_en(main_clk_en),
  .cpu_clk_en(cpu_clk_en), .req_err(req_err)
);

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/1ps
module lpm_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake = 1'b0, cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] rd [2];
  logic [2:0] md [2];
  logic mce [2], sce [2], cce [2], er [2];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] em [2];
  logic [2:0] eret [2];
  logic       eerr [2];
  logic [5:0] ecfg [2];

  always #5 clk = ~clk;

  lpm_ctrl #(.HAS_SUB(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd[0]), .mode(md[0]),
    .main_clk_en(mce[0]), .sub_clk_en(sce[0]), .cpu_clk_en(cce[0]), .req_err(er[0])
  );

  lpm_ctrl #(.HAS_SUB(1'b0)) uut_nosub (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd[1]), .mode(md[1]),
    .main_clk_en(mce[1]), .sub_clk_en(sce[1]), .cpu_clk_en(cce[1]), .req_err(er[1])
  );

  task automatic check(input string tag, input int k, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d %s actual=%0h expected=%0h", tag, k, what, act, exp);
    end
  endtask

  function automatic bit is_wait(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd4 || m == 3'd6;
  endfunction

  task automatic model_step(input int k, input logic slp, input logic wk,
                            input logic we, input logic [5:0] wd);
    logic [5:0] c;
    logic [2:0] m, t;
    bit hs, ok;
    c  = ecfg[k];
    m  = em[k];
    hs = (k == 0);
    ok = hs && !c[4];
    case (m)
      3'd0, 3'd1: begin
        if (slp) begin
          t = c[3] ? 3'd4 : c[2] ? 3'd3 : (c[0] && c[1]) ? 3'd5 : 3'd2;
          if ((t == 3'd4 || t == 3'd5) && (m == 3'd1 || !ok)) begin
            eerr[k] = 1'b1;
          end else begin
            if (t == 3'd2 || t == 3'd3) eret[k] = m;
            em[k] = t;
          end
        end else begin
          em[k] = c[5] ? 3'd1 : 3'd0;
        end
      end
      3'd5: if (slp) begin
        t = c[3] ? 3'd4 : (c[0] && !c[1]) ? 3'd0 : 3'd6;
        if (t == 3'd4 && !ok) eerr[k] = 1'b1;
        else                  em[k] = t;
      end
      3'd2, 3'd3: if (wk) em[k] = eret[k];
      3'd4:       if (wk) em[k] = c[1] ? 3'd5 : 3'd0;
      3'd6:       if (wk) em[k] = 3'd5;
      default: ;
    endcase
    if (we) ecfg[k] = hs ? wd : (wd & 6'b101100);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 2; k++) begin
      logic [2:0] m;
      m = em[k];
      check(tag, k, "mode", {5'b0, md[k]}, {5'b0, m});
      check("R6", k, "req_err", {7'b0, er[k]}, {7'b0, eerr[k]});
      check(k == 0 ? "R2" : "R11", k, "cfg_rdata", {2'b0, rd[k]}, {2'b0, ecfg[k]});
      check("R10", k, "cpu_en", {7'b0, cce[k]},
            {7'b0, (m == 3'd0 || m == 3'd1 || m == 3'd5)});
      check("R10", k, "main_en", {7'b0, mce[k]},
            {7'b0, !(m == 3'd3 || m == 3'd4 || m == 3'd5 || m == 3'd6)});
      check(k == 0 ? "R10" : "R11", k, "sub_en", {7'b0, sce[k]},
            {7'b0, (k == 0) && (!ecfg[k][4] || m == 3'd4 || m == 3'd5 || m == 3'd6)});
    end
  endtask

  task automatic cyc(input string tag, input logic slp, input logic wk,
                     input logic we, input logic [5:0] wd);
    sleep_req = slp; wake = wk; cfg_we = we; cfg_wdata = wd;
    @(posedge clk);
    for (int k = 0; k < 2; k++) model_step(k, slp, wk, we, wd);
    @(negedge clk);
    sleep_req = 1'b0; wake = 1'b0; cfg_we = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      em[k] = 3'd0; eret[k] = 3'd0; eerr[k] = 1'b0; ecfg[k] = 6'd0;
    end
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    for (int st = 0; st < 2; st++) begin
      for (int c = 0; c < 64; c++) begin
        do_reset();
        if (st == 1) begin
          cyc("R2", 1'b0, 1'b0, 1'b1, 6'h03);
          cyc("R4", 1'b1, 1'b0, 1'b0, 6'h00);
        end
        cyc("R2", 1'b0, 1'b0, 1'b1, c[5:0]);
        cyc("R3", 1'b0, 1'b0, 1'b0, 6'h00);
        cyc("R9", 1'b0, 1'b1, 1'b0, 6'h00);
        cyc(st == 1 ? "R5" : "R4", 1'b1, 1'b0, 1'b0, 6'h00);
        cyc("R9", 1'b1, 1'b0, 1'b0, 6'h00);
        cyc(em[0] == 3'd4 ? "R8" : "R7", 1'b0, 1'b1, 1'b0, 6'h00);
        cyc("R3", 1'b0, 1'b0, 1'b0, 6'h00);
        cyc("R8", 1'b0, 1'b1, 1'b0, 6'h00);
        cyc("R8", 1'b1, 1'b0, 1'b0, 6'h00);
        cyc("R8", 1'b0, 1'b1, 1'b0, 6'h00);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule